// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the instruction unit of a small 16-bit processor that keeps instructions and data in separate memories. It owns the program counter and the instruction register. A control state machine takes every instruction through a fetch cycle, a decode cycle and one or two execute cycles. From these states it drives the register-transfer controls of the surrounding datapath: register-file read and write indices, the write enable and write-source select, the ALU operation and operand-B select, the sign-extended immediate, the data-memory read and write strobes, and PC increment or load indications.

The ALU, the register file and both memories sit outside the block. The instruction memory is addressed directly by the PC and returns the word combinationally. The data-memory address is the ALU result, which the block forms by commanding an add of the base register and the instruction's offset. The only condition input is the ALU zero flag. Branches sample it in their single execute cycle.

Instruction words are 16 bits. Bits 15:13 hold the opcode: 0 register-type, 1 load, 2 store, 3 branch-if-equal, 4 add-immediate, 5 jump, 6 no-operation, 7 halt. Bits 12:10 select the first source register (rs) and bits 9:7 the second (rt). Register-type words carry the destination rd in bits 6:4 and a function code in bits 3:0. Immediate words carry a 7-bit signed offset in bits 6:0.

Top module: `mcu_ctrl`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and halted, rf_we, dmem_rd, dmem_wr, pc_inc and pc_load are all 0. After release the machine spends exactly one cycle in an initialise state before its first fetch, so the first instruction completes in the third cycle after release.
- R2: Each instruction is read from imem_addr = PC during a fetch cycle and decoded in the next cycle. Every instruction except a load completes in its third cycle; a load completes in its fourth. Exactly one of PC increment, branch load or jump load happens, in the final cycle only.
- R3: Opcode 0 with funct 0..4 drives alu_op with funct (0 add, 1 subtract, 2 AND, 3 OR, 4 set-less-than) and alu_bsel_imm=0. It writes the ALU result (rf_wsel_mem=0) to rd, then PC+1.
- R4: Opcode 0 with funct 5..15 writes no register and only advances the PC by one.
- R5: Opcode 4 drives an ALU add with alu_bsel_imm=1, where imm is bits 6:0 sign-extended to 16 bits. It writes the result to rt, then PC+1.
- R6: Opcode 1 first asserts dmem_rd with an ALU add of rs and imm. In the next cycle it writes rt with rf_wsel_mem=1 (memory data), then PC+1.
- R7: Opcode 2 asserts dmem_wr for one cycle with an ALU add of rs and imm as the address and rt on rf_rb as the data. It writes no register, then PC+1.
- R8: Opcode 3 commands an ALU subtract of rs and rt. If alu_zero is 1 the PC becomes PC plus the sign-extended offset; otherwise it becomes PC+1.
- R9: Opcode 5 loads the PC with bits 12:0 of the instruction, zero-extended.
- R10: Opcode 6 changes nothing but the PC, which advances by one.
- R11: Opcode 7 sets halted. From then on the PC is frozen and no strobe or write enable is raised until reset.
- R12: rf_we is high for at most one cycle per instruction, only in its final execute cycle. dmem_rd and dmem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 16 | Instruction-memory word address (the PC) |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| rf_ra | output | 3 | Register-file read index A (rs) |
| rf_rb | output | 3 | Register-file read index B (rt) |
| rf_wa | output | 3 | Register-file write index |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel_mem | output | 1 | Write source: 1 memory read data, 0 ALU result |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 slt |
| alu_bsel_imm | output | 1 | ALU operand B: 1 immediate, 0 read port B |
| imm | output | 16 | Sign-extended offset of the current instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe |
| pc_inc | output | 1 | PC advances by one at this edge |
| pc_load | output | 1 | PC is loaded (branch taken or jump) at this edge |
| halted | output | 1 | Machine stopped by a halt instruction |

## Verification
The branch execute cycle is where the equality test and the PC update happen together. In that one cycle the zero flag produced by the commanded subtraction decides whether the PC takes the offset or the increment. The bench runs branches with equal registers (a forward offset and a negative offset) and with unequal registers. It judges each by the address of the next fetch and by which of pc_inc or pc_load was raised. Register write-back and the PC increment also coincide in the final cycle of register, immediate and load instructions. Each of those is judged by the written index and value together with the following fetch address.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    localparam int unsigned IW     = 16;
    localparam int unsigned OPC_W  = 3;
    localparam int unsigned RIDX_W = 3;
    localparam int unsigned FN_W   = 4;
    localparam int unsigned OFF_W  = 7;
    localparam int unsigned TGT_W  = 13;
    localparam int unsigned AOP_W  = 3;

    localparam int unsigned OPC_LSB = IW - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - RIDX_W;
    localparam int unsigned RT_LSB  = RS_LSB - RIDX_W;
    localparam int unsigned RD_LSB  = RT_LSB - RIDX_W;
    localparam int unsigned FN_MAX  = 4;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_FETCH,
        ST_DECODE,
        ST_EX_RR,
        ST_EX_LDA,
        ST_EX_LDW,
        ST_EX_ST,
        ST_EX_BR,
        ST_EX_JMP,
        ST_EX_NOP,
        ST_HALT
    } state_e;

    typedef enum logic [OPC_W-1:0] {
        CL_RR   = 3'd0,
        CL_LD   = 3'd1,
        CL_ST   = 3'd2,
        CL_BR   = 3'd3,
        CL_IMM  = 3'd4,
        CL_JMP  = 3'd5,
        CL_NOP  = 3'd6,
        CL_HALT = 3'd7
    } iclass_e;

    typedef enum logic [AOP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        iclass_e             cls;
        logic [RIDX_W-1:0]   rs;
        logic [RIDX_W-1:0]   rt;
        logic [RIDX_W-1:0]   rd;
        logic                fn_ok;
        alu_op_e             fn_op;
        logic [IW-1:0]       imm;
        logic [IW-1:0]       target;
    } dec_t;

    typedef struct packed {
        logic                ir_load;
        logic                rf_we;
        logic                rf_wsel_mem;
        logic [RIDX_W-1:0]   rf_wa;
        alu_op_e             alu_op;
        logic                alu_bsel_imm;
        logic                dmem_rd;
        logic                dmem_wr;
        logic                pc_inc;
        logic                pc_br;
        logic                pc_jmp;
        logic                halted;
    } ctl_t;

endpackage

// File: rtl/mcu_decode.sv
module mcu_decode
    import mcu_pkg::*;
(
    input  logic [IW-1:0] ir,
    output dec_t          dec
);

    logic [FN_W-1:0] fn;

    always_comb begin
        fn         = ir[FN_W-1:0];
        dec.cls    = iclass_e'(ir[IW-1 -: OPC_W]);
        dec.rs     = ir[RS_LSB +: RIDX_W];
        dec.rt     = ir[RT_LSB +: RIDX_W];
        dec.rd     = ir[RD_LSB +: RIDX_W];
        dec.fn_ok  = (fn <= FN_W'(FN_MAX));
        dec.fn_op  = dec.fn_ok ? alu_op_e'(fn[AOP_W-1:0]) : ALU_ADD;
        dec.imm    = {{(IW-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};
        dec.target = {{(IW-TGT_W){1'b0}}, ir[TGT_W-1:0]};
    end

endmodule

// File: rtl/mcu_seq.sv
module mcu_seq
    import mcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  iclass_e           cls,
    input  logic              fn_ok,
    input  alu_op_e           fn_op,
    input  logic [RIDX_W-1:0] rt,
    input  logic [RIDX_W-1:0] rd,
    input  logic              alu_zero,
    output state_e            state,
    output ctl_t              ctl
);

    typedef struct packed {
        state_e state;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_INIT:   s_d.state = ST_FETCH;
            ST_FETCH:  s_d.state = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_RR, CL_IMM: s_d.state = ST_EX_RR;
                    CL_LD:         s_d.state = ST_EX_LDA;
                    CL_ST:         s_d.state = ST_EX_ST;
                    CL_BR:         s_d.state = ST_EX_BR;
                    CL_JMP:        s_d.state = ST_EX_JMP;
                    CL_NOP:        s_d.state = ST_EX_NOP;
                    CL_HALT:       s_d.state = ST_HALT;
                    default:       s_d.state = ST_HALT;
                endcase
            end
            ST_EX_LDA: s_d.state = ST_EX_LDW;
            ST_HALT:   s_d.state = ST_HALT;
            default:   s_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl              = '0;
        ctl.alu_op       = ALU_ADD;
        ctl.rf_wa        = rt;
        unique case (s_q.state)
            ST_FETCH: ctl.ir_load = 1'b1;
            ST_EX_RR: begin
                ctl.alu_op       = (cls == CL_RR) ? fn_op : ALU_ADD;
                ctl.alu_bsel_imm = (cls == CL_IMM);
                ctl.rf_we        = (cls == CL_IMM) || fn_ok;
                ctl.rf_wa        = (cls == CL_RR) ? rd : rt;
                ctl.pc_inc       = 1'b1;
            end
            ST_EX_LDA: begin
                ctl.alu_bsel_imm = 1'b1;
                ctl.dmem_rd      = 1'b1;
            end
            ST_EX_LDW: begin
                ctl.alu_bsel_imm = 1'b1;
                ctl.rf_we        = 1'b1;
                ctl.rf_wsel_mem  = 1'b1;
                ctl.pc_inc       = 1'b1;
            end
            ST_EX_ST: begin
                ctl.alu_bsel_imm = 1'b1;
                ctl.dmem_wr      = 1'b1;
                ctl.pc_inc       = 1'b1;
            end
            ST_EX_BR: begin
                ctl.alu_op = ALU_SUB;
                ctl.pc_br  = alu_zero;
                ctl.pc_inc = !alu_zero;
            end
            ST_EX_JMP: ctl.pc_jmp = 1'b1;
            ST_EX_NOP: ctl.pc_inc = 1'b1;
            ST_HALT:   ctl.halted = 1'b1;
            default:   ctl.ir_load = 1'b0;
        endcase
    end

    assign state = s_q.state;

    // R1: the initialise state lasts exactly one cycle
    p_init_to_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_INIT) |=> (s_q.state == ST_FETCH));

    // R6: address phase of a load is always followed by its write-back phase
    p_ld_two_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_EX_LDA) |=> (s_q.state == ST_EX_LDW));

    // R11: only reset leaves the halt state
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.halted |=> ctl.halted);

    // R12: write enable never lasts two cycles
    p_we_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rf_we |=> !ctl.rf_we);

    // R12: data memory strobes exclusive
    p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.dmem_rd && ctl.dmem_wr));

endmodule

// File: rtl/mcu_pcir.sv
module mcu_pcir
    import mcu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ir_load,
    input  logic [IW-1:0] imem_rdata,
    input  logic          pc_inc,
    input  logic          pc_br,
    input  logic          pc_jmp,
    input  logic [IW-1:0] imm,
    input  logic [IW-1:0] target,
    output logic [IW-1:0] pc,
    output logic [IW-1:0] ir
);

    typedef struct packed {
        logic [IW-1:0] pc;
        logic [IW-1:0] ir;
    } pcir_t;

    pcir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ir_load) begin
            r_d.ir = imem_rdata;
        end
        if (pc_jmp) begin
            r_d.pc = target;
        end else if (pc_br) begin
            r_d.pc = r_q.pc + imm;
        end else if (pc_inc) begin
            r_d.pc = r_q.pc + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc = r_q.pc;
    assign ir = r_q.ir;

    // R2: at most one PC source per cycle
    p_pc_one_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_inc, pc_br, pc_jmp}));

    // R9: jump lands on the target field
    p_jmp_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_jmp |=> (pc == $past(target)));

endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
    import mcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [IW-1:0]     imem_addr,
    input  logic [IW-1:0]     imem_rdata,
    output logic [RIDX_W-1:0] rf_ra,
    output logic [RIDX_W-1:0] rf_rb,
    output logic [RIDX_W-1:0] rf_wa,
    output logic              rf_we,
    output logic              rf_wsel_mem,
    output logic [AOP_W-1:0]  alu_op,
    output logic              alu_bsel_imm,
    output logic [IW-1:0]     imm,
    input  logic              alu_zero,
    output logic              dmem_rd,
    output logic              dmem_wr,
    output logic              pc_inc,
    output logic              pc_load,
    output logic              halted
);

    logic [IW-1:0] ir;
    logic [IW-1:0] pc;
    dec_t          dec;
    ctl_t          ctl;
    state_e        state;

    mcu_decode u_decode (
        .ir  (ir),
        .dec (dec)
    );

    mcu_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (dec.cls),
        .fn_ok    (dec.fn_ok),
        .fn_op    (dec.fn_op),
        .rt       (dec.rt),
        .rd       (dec.rd),
        .alu_zero (alu_zero),
        .state    (state),
        .ctl      (ctl)
    );

    mcu_pcir u_pcir (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_load    (ctl.ir_load),
        .imem_rdata (imem_rdata),
        .pc_inc     (ctl.pc_inc),
        .pc_br      (ctl.pc_br),
        .pc_jmp     (ctl.pc_jmp),
        .imm        (dec.imm),
        .target     (dec.target),
        .pc         (pc),
        .ir         (ir)
    );

    assign imem_addr    = pc;
    assign rf_ra        = dec.rs;
    assign rf_rb        = dec.rt;
    assign rf_wa        = ctl.rf_wa;
    assign rf_we        = ctl.rf_we;
    assign rf_wsel_mem  = ctl.rf_wsel_mem;
    assign alu_op       = ctl.alu_op;
    assign alu_bsel_imm = ctl.alu_bsel_imm;
    assign imm          = dec.imm;
    assign dmem_rd      = ctl.dmem_rd;
    assign dmem_wr      = ctl.dmem_wr;
    assign pc_inc       = ctl.pc_inc;
    assign pc_load      = ctl.pc_br | ctl.pc_jmp;
    assign halted       = ctl.halted;

    // R2: instruction register holds outside the fetch cycle
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |=> $stable(ir));

    // R8: an unequal compare falls through to the next word
    p_br_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EX_BR && !alu_zero) |=> (imem_addr == $past(imem_addr) + IW'(1)));

    // R11: PC frozen while halted
    p_halt_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));

endmodule

// File: tb/mcu_ctrl_bench.sv
`timescale 1ns/1ps
module mcu_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr, imem_rdata, imm;
    logic [2:0]  rf_ra, rf_rb, rf_wa, alu_op;
    logic        rf_we, rf_wsel_mem, alu_bsel_imm, alu_zero;
    logic        dmem_rd, dmem_wr, pc_inc, pc_load, halted;

    always #5 clk = ~clk;

    mcu_ctrl u_mcu_ctrl (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .rf_ra(rf_ra), .rf_rb(rf_rb), .rf_wa(rf_wa), .rf_we(rf_we),
        .rf_wsel_mem(rf_wsel_mem), .alu_op(alu_op), .alu_bsel_imm(alu_bsel_imm),
        .imm(imm), .alu_zero(alu_zero), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .pc_inc(pc_inc), .pc_load(pc_load), .halted(halted)
    );

    // behavioural datapath models
    logic [15:0] imem [64];
    logic [15:0] dmem [64];
    logic [15:0] regs [8];
    logic [15:0] dmem_q, op_a, op_b, alu_res, wdata;

    assign imem_rdata = imem[imem_addr[5:0]];
    assign op_a = regs[rf_ra];
    assign op_b = alu_bsel_imm ? imm : regs[rf_rb];
    always_comb begin
        case (alu_op)
            3'd0:    alu_res = op_a + op_b;
            3'd1:    alu_res = op_a - op_b;
            3'd2:    alu_res = op_a & op_b;
            3'd3:    alu_res = op_a | op_b;
            3'd4:    alu_res = {15'd0, $signed(op_a) < $signed(op_b)};
            default: alu_res = 16'hDEAD;
        endcase
    end
    assign alu_zero = (alu_res == 16'd0);
    assign wdata = rf_wsel_mem ? dmem_q : alu_res;

    always @(posedge clk) begin
        if (rf_we) regs[rf_wa] <= wdata;
        if (dmem_wr) dmem[alu_res[5:0]] <= regs[rf_rb];
        if (dmem_rd) dmem_q <= dmem[alu_res[5:0]];
    end

    typedef struct packed {
        logic [15:0] pc;
        logic [15:0] ins;
        logic        we;
        logic [2:0]  wa;
        logic [15:0] wd;
        logic        mw;
        logic [15:0] npc;
        logic [3:0]  cyc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h8085, 1'b1, 3'd1, 16'h0005, 1'b0, 16'h0001, 4'd3}, // R5 addi r1=5
        '{16'h0001, 16'h817D, 1'b1, 3'd2, 16'hFFFD, 1'b0, 16'h0002, 4'd3}, // R5 addi r2=-3
        '{16'h0002, 16'h0530, 1'b1, 3'd3, 16'h0002, 1'b0, 16'h0003, 4'd3}, // R3 add
        '{16'h0003, 16'h0541, 1'b1, 3'd4, 16'h0008, 1'b0, 16'h0004, 4'd3}, // R3 sub
        '{16'h0004, 16'h0552, 1'b1, 3'd5, 16'h0005, 1'b0, 16'h0005, 4'd3}, // R3 and
        '{16'h0005, 16'h0563, 1'b1, 3'd6, 16'hFFFD, 1'b0, 16'h0006, 4'd3}, // R3 or
        '{16'h0006, 16'h08F4, 1'b1, 3'd7, 16'h0001, 1'b0, 16'h0007, 4'd3}, // R3 slt
        '{16'h0007, 16'h4C84, 1'b0, 3'd0, 16'h0000, 1'b1, 16'h0008, 4'd3}, // R7 sw
        '{16'h0008, 16'h2E04, 1'b1, 3'd4, 16'h0005, 1'b0, 16'h0009, 4'd4}, // R6 lw
        '{16'h0009, 16'h6603, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h000C, 4'd3}, // R8 taken
        '{16'h000C, 16'h6505, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h000D, 4'd3}, // R8 not taken
        '{16'h000D, 16'h0559, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h000E, 4'd3}, // R4 bad funct
        '{16'h000E, 16'hC000, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h000F, 4'd3}, // R10 nop
        '{16'h000F, 16'hA020, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h0020, 4'd3}, // R9 jump
        '{16'h0020, 16'h607E, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h001E, 4'd3}, // R8 back
        '{16'h001E, 16'h8007, 1'b1, 3'd0, 16'h0007, 1'b0, 16'h001F, 4'd3}  // R5 r0=7
    };

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_end();
        while (!(pc_inc || pc_load) && cnt < 12) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 16'hC000;
            dmem[i] = 16'h0000;
        end
        for (int i = 0; i < 8; i++) regs[i] = 16'h0000;
        for (int i = 0; i < NV; i++) imem[VEC[i].pc[5:0]] = VEC[i].ins;
        imem[6'h1F] = 16'hE000;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(imem_addr == 16'd0, "R1 pc in reset", 32'(imem_addr), 0);
        check({halted, rf_we, dmem_rd, dmem_wr, pc_inc, pc_load} == 6'd0,
              "R1 strobes in reset", 32'({halted, rf_we, dmem_rd, dmem_wr, pc_inc, pc_load}), 0);
        rst_n = 1'b1;
        cnt = 0;

        for (int i = 0; i < NV; i++) begin
            wait_end();
            check(cnt == int'(VEC[i].cyc), "R2 cycles", 32'(cnt), 32'(VEC[i].cyc));
            check(rf_we == VEC[i].we, "R12 write enable", 32'(rf_we), 32'(VEC[i].we));
            if (VEC[i].we) begin
                check(rf_wa == VEC[i].wa, "R3 write index", 32'(rf_wa), 32'(VEC[i].wa));
                check(wdata == VEC[i].wd, "R5 write value", 32'(wdata), 32'(VEC[i].wd));
            end
            check(dmem_wr == VEC[i].mw, "R7 store strobe", 32'(dmem_wr), 32'(VEC[i].mw));
            if (VEC[i].mw)
                check(alu_res == 16'd6 && regs[rf_rb] == 16'd5, "R7 store addr/data",
                      32'({alu_res, regs[rf_rb]}), 32'h00060005);
            @(negedge clk);
            cnt = 1;
            check(imem_addr == VEC[i].npc, "R8 next pc", 32'(imem_addr), 32'(VEC[i].npc));
        end

        // R11 halt
        repeat (2) @(negedge clk);
        check(halted == 1'b1, "R11 halted", 32'(halted), 1);
        begin
            bit bad = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (imem_addr != 16'h1F || rf_we || dmem_rd || dmem_wr || pc_inc ||
                    pc_load || !halted) bad = 1'b1;
            end
            check(!bad, "R11 stays halted", 32'(imem_addr), 32'h1F);
        end
        check(regs[5] == 16'h0005, "R4 rd untouched", 32'(regs[5]), 5);

        // R1 reset leaves halt, machine restarts at 0
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(imem_addr == 16'd0 && !halted, "R1 reset from halt",
              32'({halted, imem_addr}), 0);
        rst_n = 1'b1;
        cnt = 0;
        wait_end();
        check(cnt == 3, "R1 init then fetch", 32'(cnt), 3);
        check(rf_we && rf_wa == 3'd1 && wdata == 16'd12, "R5 addi after restart",
              32'(wdata), 12);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule